// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Drive Mode

This block implements one bank of general-purpose pins, 4 to 8 wide, behind a small byte-wide configuration port. Four consecutive registers, starting at a bank base address aligned to 16 bytes, hold the pin direction, the output latch, the synchronized pin input levels and the per-pin drive mode. Software normally writes the output latch first and the direction second, so a pin starts driving at the level it was given.

Each pad receives an output-enable and an output value. An input pin never drives. A push-pull output drives both levels. An open-drain output pulls low for a latch value of 0 and releases the line for a latch value of 1. The pad inputs pass through a two-flop synchronizer and can be read back whatever the direction of the pin. The output latch reads back the value written to it, not the level on the pad.

Top module: `gpio_drive_bank`

## Requirements
- R1: After reset, the direction, output latch and drive mode registers read 0, so every pin is an open-drain input, and pad_oe and pad_out are all 0.
- R2: The block responds only when the address bits above the low four match the bank base. Offset 0 is direction, 1 is output latch, 2 is input status and 3 is drive mode. Offsets 4 to 15 and other banks read 0, and writes to them change no register.
- R3: A direction bit of 0 makes the pin an input: its pad_oe bit is 0 and its pad_out bit is 0.
- R4: A direction bit of 1 with a drive-mode bit of 1 selects push-pull output: pad_oe is 1 and pad_out equals the latch bit.
- R5: A direction bit of 1 with a drive-mode bit of 0 selects open-drain output: a latch bit of 0 gives pad_oe 1 with pad_out 0, and a latch bit of 1 gives pad_oe 0. pad_out is always 0 in this mode.
- R6: The output latch register reads back the value written to it, whatever the pad levels are.
- R7: The input status register returns every pad level through two synchronizer flops. A pad change made just before a clock edge is visible to a read issued in the third cycle, but not in the first two.
- R8: Writes to the input status offset are ignored.
- R9: Register bits at or above the pin count read 0 and ignore writes.
- R10: Setting a direction bit keeps the latch value already written, so the pad drives that level from the first cycle after the direction write.
- R11: cfg_rdata is loaded on the clock edge where cfg_rd is high and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rd | input | 1 | Read strobe, data valid in the next cycle |
| cfg_rdata | output | DATA_W | Registered read data |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_oe | output | NUM_PINS | Pad output enable per pin |
| pad_out | output | NUM_PINS | Pad output value per pin |

## Verification
The drive logic is swept over all 512 combinations of direction, drive mode and latch bit, applied as three-bit groups repeated across a 6-pin bank. This shows each of the eight per-pin states on two pins at once, and tells input, push-pull and open-drain behaviour apart. The address decoder is tried with the bank's own offsets, with out-of-range offsets and with a neighbouring bank address, which separates the tag match from the offset decode. Readback is tried with a latch opposite to the pad levels, with pads that change just before three back-to-back reads, and with data bits above the pin count. These patterns distinguish latch from pad readback, the exact synchronizer delay and the masking of absent pins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // Each bank occupies a 16-byte window; the low address bits pick a register.
   localparam int STRIDE_BITS = 4;

   localparam logic [STRIDE_BITS-1:0] OFF_DIR  = 4'd0;
   localparam logic [STRIDE_BITS-1:0] OFF_DOUT = 4'd1;
   localparam logic [STRIDE_BITS-1:0] OFF_DIN  = 4'd2;
   localparam logic [STRIDE_BITS-1:0] OFF_MODE = 4'd3;

   typedef enum logic {
      DRV_OPEN_DRAIN = 1'b0,
      DRV_PUSH_PULL  = 1'b1
   } drive_mode_e;

endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int NUM_PINS = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hF0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic                cfg_wr,
   input  logic [DATA_W-1:0]   cfg_wdata,
   input  logic                cfg_rd,
   output logic [DATA_W-1:0]   cfg_rdata,
   input  logic [NUM_PINS-1:0] pin_status,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] dout_q,
   output logic [NUM_PINS-1:0] mode_q
);

   localparam int TAG_HI = ADDR_W - 1;

   logic                   bank_hit;
   logic [STRIDE_BITS-1:0] reg_off;
   logic                   wr_dir, wr_dout, wr_mode;
   logic [NUM_PINS-1:0]    rd_sel;
   logic [DATA_W-1:0]      rd_word;
   logic [DATA_W-1:0]      rdata_q;

   assign bank_hit = (cfg_addr[TAG_HI:STRIDE_BITS] == BASE_ADDR[TAG_HI:STRIDE_BITS]);
   assign reg_off  = cfg_addr[STRIDE_BITS-1:0];

   assign wr_dir  = cfg_wr && bank_hit && (reg_off == OFF_DIR);
   assign wr_dout = cfg_wr && bank_hit && (reg_off == OFF_DOUT);
   assign wr_mode = cfg_wr && bank_hit && (reg_off == OFF_MODE);

   generate
      if (DATA_W > NUM_PINS) begin : g_wdata_hi
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:NUM_PINS];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         dout_q <= '0;
         mode_q <= {NUM_PINS{DRV_OPEN_DRAIN}};
      end else begin
         if (wr_dir)  dir_q  <= cfg_wdata[NUM_PINS-1:0];
         if (wr_dout) dout_q <= cfg_wdata[NUM_PINS-1:0];
         if (wr_mode) mode_q <= cfg_wdata[NUM_PINS-1:0];
      end
   end

   always_comb begin
      rd_sel = '0;
      if (bank_hit) begin
         case (reg_off)
            OFF_DIR:  rd_sel = dir_q;
            OFF_DOUT: rd_sel = dout_q;
            OFF_DIN:  rd_sel = pin_status;
            OFF_MODE: rd_sel = mode_q;
            default:  rd_sel = '0;
         endcase
      end
      rd_word = '0;
      rd_word[NUM_PINS-1:0] = rd_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else if (cfg_rd) rdata_q <= rd_word;
   end

   assign cfg_rdata = rdata_q;

   // R2
   foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !bank_hit) |=> ($stable(dir_q) && $stable(dout_q) && $stable(mode_q)));

   // R8
   status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && bank_hit && reg_off == OFF_DIN) |=>
         ($stable(dir_q) && $stable(dout_q) && $stable(mode_q)));

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd |=> $stable(cfg_rdata));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NUM_PINS = 8,
   parameter int STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] status
);

   logic [NUM_PINS-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= pad_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign status = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
   import gpio_bank_pkg::*;
#(
   parameter int NUM_PINS = 8
) (
   input  logic [NUM_PINS-1:0] dir,
   input  logic [NUM_PINS-1:0] dout,
   input  logic [NUM_PINS-1:0] mode,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out
);

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         drive_mode_e pin_mode;
         assign pin_mode = drive_mode_e'(mode[p]);

         always_comb begin
            pad_oe[p]  = 1'b0;
            pad_out[p] = 1'b0;
            if (dir[p]) begin
               if (pin_mode == DRV_PUSH_PULL) begin
                  pad_oe[p]  = 1'b1;
                  pad_out[p] = dout[p];
               end else begin
                  // Release the line for a high; pull low otherwise.
                  pad_oe[p]  = ~dout[p];
                  pad_out[p] = 1'b0;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_drive_bank.sv
module gpio_drive_bank
   import gpio_bank_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int NUM_PINS = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hF0,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic                cfg_wr,
   input  logic [DATA_W-1:0]   cfg_wdata,
   input  logic                cfg_rd,
   output logic [DATA_W-1:0]   cfg_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out
);

   generate
      if (NUM_PINS < 4 || NUM_PINS > 8) begin : g_bad_pins
         $error("gpio_drive_bank supports 4 to 8 pins");
      end
      if (NUM_PINS > DATA_W) begin : g_bad_width
         $error("gpio_drive_bank pin count exceeds data width");
      end
      if (ADDR_W <= STRIDE_BITS) begin : g_bad_addr
         $error("gpio_drive_bank address too narrow for bank tag");
      end
      if (BASE_ADDR[STRIDE_BITS-1:0] != '0) begin : g_bad_base
         $error("gpio_drive_bank base must be 16-byte aligned");
      end
   endgenerate

   logic [NUM_PINS-1:0] dir_q, dout_q, mode_q, pin_status;

   gpio_in_sync #(
      .NUM_PINS(NUM_PINS),
      .STAGES  (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pad_in(pad_in),
      .status(pin_status)
   );

   gpio_bank_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_PINS (NUM_PINS),
      .BASE_ADDR(BASE_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_addr  (cfg_addr),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_rd    (cfg_rd),
      .cfg_rdata (cfg_rdata),
      .pin_status(pin_status),
      .dir_q     (dir_q),
      .dout_q    (dout_q),
      .mode_q    (mode_q)
   );

   gpio_pad_drive #(
      .NUM_PINS(NUM_PINS)
   ) u_drive (
      .dir    (dir_q),
      .dout   (dout_q),
      .mode   (mode_q),
      .pad_oe (pad_oe),
      .pad_out(pad_out)
   );

   // R3
   input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe | pad_out) & ~dir_q) == '0);

   // R4
   push_pull_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dir_q & mode_q) & ~pad_oe) == '0);

   // R5
   open_drain_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~mode_q) == '0);

endmodule

// File: tb/sim_gpio_drive_bank.sv
`timescale 1ns/1ps
module sim_gpio_drive_bank;

   localparam int NP = 6;
   localparam logic [7:0] BASE = 8'hD0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] cfg_addr = '0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       cfg_rd = 1'b0;
   logic [7:0] cfg_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_oe, pad_out;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_drive_bank #(
      .ADDR_W(8), .DATA_W(8), .NUM_PINS(NP), .BASE_ADDR(BASE), .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      cfg_addr = a; cfg_rd = 1'b1;
      @(negedge clk);
      cfg_rd = 1'b0;
      d = cfg_rdata;
   endtask

   initial begin
      logic [7:0] v;
      logic [NP-1:0] dv, mv, ov;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pad_oe", 8'(pad_oe), 8'h00);
      chk("R1 pad_out", 8'(pad_out), 8'h00);
      rd(BASE + 8'd0, v); chk("R1 dir", v, 8'h00);
      rd(BASE + 8'd1, v); chk("R1 dout", v, 8'h00);
      rd(BASE + 8'd3, v); chk("R1 mode", v, 8'h00);

      // R3 R4 R5 exhaustive drive sweep, each 3-bit group repeated on pins 5:3 and 2:0
      for (int d = 0; d < 8; d++) begin
         for (int m = 0; m < 8; m++) begin
            for (int o = 0; o < 8; o++) begin
               dv = {d[2:0], d[2:0]};
               mv = {m[2:0], m[2:0]};
               ov = {o[2:0], o[2:0]};
               wr(BASE + 8'd3, 8'(mv));
               wr(BASE + 8'd1, 8'(ov));
               wr(BASE + 8'd0, 8'(dv));
               chk("R3 R4 R5 pad_oe", 8'(pad_oe), 8'(dv & (mv | ~ov)));
               chk("R3 R4 R5 pad_out", 8'(pad_out), 8'(dv & mv & ov));
            end
         end
      end

      // R6 latch readback is not the pad level
      wr(BASE + 8'd0, 8'h00);
      wr(BASE + 8'd1, 8'h15);
      pad_in = 6'h2A;
      repeat (3) @(negedge clk);
      rd(BASE + 8'd1, v); chk("R6 dout readback", v, 8'h15);

      // R7 input status for input and output pins, and exact latency
      wr(BASE + 8'd0, 8'h0F);
      rd(BASE + 8'd2, v); chk("R7 status mixed dir", v, 8'h2A);
      pad_in = 6'h11;
      rd(BASE + 8'd2, v); chk("R7 status cycle1", v, 8'h2A);
      rd(BASE + 8'd2, v); chk("R7 status cycle2", v, 8'h2A);
      rd(BASE + 8'd2, v); chk("R7 status cycle3", v, 8'h11);

      // R8 writes to the status offset are ignored
      wr(BASE + 8'd2, 8'hFF);
      rd(BASE + 8'd2, v); chk("R8 status", v, 8'h11);
      rd(BASE + 8'd0, v); chk("R8 dir", v, 8'h0F);
      rd(BASE + 8'd1, v); chk("R8 dout", v, 8'h15);

      // R9 absent pin bits
      wr(BASE + 8'd0, 8'hFF);
      rd(BASE + 8'd0, v); chk("R9 dir masked", v, 8'h3F);
      wr(BASE + 8'd3, 8'hC0);
      rd(BASE + 8'd3, v); chk("R9 mode high bits", v, 8'h00);
      pad_in = 6'h3F;
      repeat (3) @(negedge clk);
      rd(BASE + 8'd2, v); chk("R9 status width", v, 8'h3F);

      // R2 decode: out-of-range offset and neighbouring banks
      wr(BASE + 8'd4, 8'hFF);
      rd(BASE + 8'd4, v); chk("R2 offset 4", v, 8'h00);
      wr(8'hE0, 8'h00);
      wr(8'hE1, 8'h00);
      rd(BASE + 8'd0, v); chk("R2 other bank dir", v, 8'h3F);
      rd(BASE + 8'd1, v); chk("R2 other bank dout", v, 8'h15);
      rd(8'hC1, v); chk("R2 foreign read", v, 8'h00);
      rd(BASE + 8'd15, v); chk("R2 offset 15", v, 8'h00);

      // R10 latch preset before direction gives the level in the first cycle
      wr(BASE + 8'd0, 8'h00);
      wr(BASE + 8'd3, 8'h07);
      wr(BASE + 8'd1, 8'h05);
      chk("R10 still input", 8'(pad_oe), 8'h00);
      wr(BASE + 8'd0, 8'h3F);
      chk("R10 first oe", 8'(pad_oe), 8'h3F);
      chk("R10 first out", 8'(pad_out), 8'h05);
      rd(BASE + 8'd1, v); chk("R10 latch kept", v, 8'h05);

      // R11 read data holds without a read strobe
      rd(BASE + 8'd3, v); chk("R11 read mode", v, 8'h07);
      wr(BASE + 8'd3, 8'h00);
      @(negedge clk);
      chk("R11 hold", cfg_rdata, 8'h07);
      rd(BASE + 8'd3, v); chk("R11 reload", v, 8'h00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule